// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block sits after a two-ratio prescaler and sets the overall division of a frequency synthesiser's feedback path. It runs on the prescaler's output clock and counts those pulses. It also drives a modulus line back to the prescaler. For the first A pulses of every cycle, the line asks the prescaler for its high ratio N+1. For the remaining pulses of the cycle, it asks for the low ratio N. A cycle is M prescaler pulses long. One cycle therefore spans M·N + A input cycles.

A static select picks a low ratio of 16 or 8. The chosen ratio is sent to the prescaler on its own output. The M word, the A word and the ratio select are taken into shadow registers only on the clock edge that closes a cycle. Software may rewrite them at any time, and a cycle already running always finishes on the values it started with. A status output reports when the values in use cannot give the requested ratio.

Top module: `dm_swallow_div`

## Requirements
- R1: With ratio_sel = 0 (low ratio 16), each output cycle spans M·16 + A prescaler input cycles, where the bench counts 17 for a prescaler pulse with mod_ctl high and 16 for one with it low.
- R2: With ratio_sel = 1 (low ratio 8), each cycle spans M·8 + A input cycles. psc_div8 shows the ratio_sel value that was taken at the cycle boundary and holds it for the whole cycle.
- R3: mod_ctl is high for exactly the first A prescaler pulses of a cycle. It is then low until the cycle ends and never rises again inside that cycle.
- R4: div_pulse is high on the final prescaler pulse of each cycle only. A cycle lasts exactly M prescaler pulses.
- R5: m_word, a_word and ratio_sel are sampled only on the edge that ends a cycle. A change made partway through a cycle has no effect until the next cycle.
- R6: When ratio_sel = 1, bit 3 of a_word is ignored, so only a_word[2:0] sets A. A set bit 3 also raises cfg_invalid.
- R7: cfg_invalid is high for a whole cycle when the words taken at its start have an effective A greater than M, or M = 0. It is low otherwise.
- R8: M = 0 behaves like M = 1, giving one prescaler pulse per cycle.
- R9: Ratios step by one down to N·(N−1). For N = 16, M = 15 with A from 0 to 15 gives 240 to 255, and M = 16 with A = 0 gives 256. For N = 8, M = 7 gives 56 to 63.
- R10: Reset is synchronous and active low. While reset is held, the position returns to the start of a cycle and the shadow registers take the current words. With M = 10 and A = 3, mod_ctl reads 1 and div_pulse reads 0.
- R11: The largest setting, M = 32767 with A = 15 and N = 16, gives a ratio of 524287.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ratio_sel | input | 1 | 0 selects ratios 16/17, 1 selects ratios 8/9 |
| m_word | input | 15 | Number of prescaler pulses per cycle (M) |
| a_word | input | 4 | Number of high-ratio pulses per cycle (A) |
| mod_ctl | output | 1 | 1 asks the prescaler for N+1, 0 asks for N |
| div_pulse | output | 1 | High on the last prescaler pulse of each cycle |
| psc_div8 | output | 1 | Low-ratio select passed to the prescaler (1 = 8/9) |
| cfg_invalid | output | 1 | The words in use are inconsistent (A > M or M = 0) |

## Verification
The hardest situation to reach from the ports is a word change that lands inside a running cycle. When it happens, the cycle in progress has to finish on the old M, A and ratio while the next cycle picks up the new ones. The bench first waits for a div_pulse so that it knows where a cycle starts. It then lets four prescaler pulses pass and rewrites all three inputs, including the ratio select. It measures the old cycle and then the new one separately. The largest M setting is reached in the same way. The bench synchronises on a boundary and then counts a single 32767-pulse cycle.

// File: rtl/divr_pkg.sv
// Package: shared defaults and encodings for the pulse-swallow divider.
// Assumes the M field is at least as wide as the A field.
package divr_pkg;
    localparam int DEF_M_W = 15;
    localparam int DEF_A_W = 4;

    // Low-ratio select, as passed to the prescaler.
    typedef enum logic {
        RATIO_16_17 = 1'b0,
        RATIO_8_9   = 1'b1
    } ratio_e;

    // Modulus request on the control line.
    typedef enum logic {
        MOD_LOW  = 1'b0,
        MOD_HIGH = 1'b1
    } mod_e;
endpackage

// File: rtl/divr_word_reg.sv
// Shadow registers for M, A and the ratio select.
// The registers load while reset is held and again on every cycle boundary.
// In 8/9 mode the top A bit is masked off; a set top bit, M = 0, or
// an effective A above M are recorded as inconsistent.
// Assumes M_W >= A_W and A_W >= 2.
module divr_word_reg #(
    parameter int M_W = divr_pkg::DEF_M_W,
    parameter int A_W = divr_pkg::DEF_A_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    input  logic           sel_in,
    output logic [M_W-1:0] m_q,
    output logic [A_W-1:0] a_q,
    output logic           sel_q,
    output logic           bad_q
);
    import divr_pkg::*;

    logic [A_W-1:0] a_eff;
    logic           top_bad;
    logic           bad_nx;

    // Drop the unused A bit when the 8/9 ratio is chosen.
    always_comb begin
        a_eff   = a_in;
        top_bad = 1'b0;
        if (ratio_e'(sel_in) == RATIO_8_9) begin
            a_eff[A_W-1] = 1'b0;
            top_bad      = a_in[A_W-1];
        end
    end

    // Consistency of the incoming words.
    assign bad_nx = top_bad || (m_in == '0) || (M_W'(a_eff) > m_in);

    // Capture the words during reset and at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            m_q   <= m_in;
            a_q   <= a_eff;
            sel_q <= sel_in;
            bad_q <= bad_nx;
        end
    end
endmodule

// File: rtl/divr_pos_cnt.sv
// Position counter within one M cycle.
// It counts prescaler pulses from 0 and flags the last one, at position M-1.
// An M of zero makes every position the last, so it acts as M = 1.
module divr_pos_cnt #(
    parameter int M_W = divr_pkg::DEF_M_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_len,
    output logic [M_W-1:0] pos,
    output logic           last
);
    logic [M_W:0] pos_inc;

    // Position of the next pulse, one bit wider so it cannot wrap.
    assign pos_inc = {1'b0, pos} + (M_W+1)'(1);
    assign last    = (pos_inc >= {1'b0, m_len});

    // Advance, or return to the start after the last pulse or under reset.
    always_ff @(posedge clk) begin
        if (!rst_n || last) pos <= '0;
        else                pos <= pos_inc[M_W-1:0];
    end
endmodule

// File: rtl/divr_swallow.sv
// Modulus decision: ask for the high ratio while the position is below A.
// This makes the high-ratio pulses the first A of each cycle.
module divr_swallow #(
    parameter int M_W = divr_pkg::DEF_M_W,
    parameter int A_W = divr_pkg::DEF_A_W
) (
    input  logic [M_W-1:0] pos,
    input  logic [A_W-1:0] a_len,
    output logic           mod_ctl
);
    import divr_pkg::*;

    mod_e req;

    // Compare the position against the swallow count.
    always_comb begin
        req = (pos < M_W'(a_len)) ? MOD_HIGH : MOD_LOW;
    end

    assign mod_ctl = logic'(req);
endmodule

// File: rtl/dm_swallow_div.sv
// Top of the pulse-swallow divider controller.
// It is clocked by the prescaler output and produces one div_pulse per
// M prescaler pulses, for a total ratio of M*N + A.
// Assumes the prescaler applies mod_ctl and psc_div8 to the division
// that is running while they are presented.
module dm_swallow_div #(
    parameter int M_W = divr_pkg::DEF_M_W,
    parameter int A_W = divr_pkg::DEF_A_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ratio_sel,
    input  logic [M_W-1:0] m_word,
    input  logic [A_W-1:0] a_word,
    output logic           mod_ctl,
    output logic           div_pulse,
    output logic           psc_div8,
    output logic           cfg_invalid
);
    logic [M_W-1:0] m_q;
    logic [A_W-1:0] a_q;
    logic [M_W-1:0] pos;
    logic           last;

    divr_word_reg #(.M_W(M_W), .A_W(A_W)) u_words (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (last),
        .m_in   (m_word),
        .a_in   (a_word),
        .sel_in (ratio_sel),
        .m_q    (m_q),
        .a_q    (a_q),
        .sel_q  (psc_div8),
        .bad_q  (cfg_invalid)
    );

    divr_pos_cnt #(.M_W(M_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .m_len (m_q),
        .pos   (pos),
        .last  (last)
    );

    divr_swallow #(.M_W(M_W), .A_W(A_W)) u_swallow (
        .pos     (pos),
        .a_len   (a_q),
        .mod_ctl (mod_ctl)
    );

    assign div_pulse = last;
endmodule

// File: rtl/dm_swallow_div_chk.sv
// Checker for dm_swallow_div, attached by bind below.
// It tracks cycle length and high-ratio count against the words seen at
// the previous boundary.
module dm_swallow_div_chk #(
    parameter int M_W = divr_pkg::DEF_M_W,
    parameter int A_W = divr_pkg::DEF_A_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ratio_sel,
    input logic [M_W-1:0] m_word,
    input logic [A_W-1:0] a_word,
    input logic           mod_ctl,
    input logic           div_pulse,
    input logic           psc_div8,
    input logic           cfg_invalid
);
    logic           armed;
    logic [M_W:0]   len_q;
    logic [M_W:0]   modn_q;
    logic [M_W:0]   exp_len;
    logic [M_W:0]   exp_a;
    logic           exp_ok;
    logic [A_W-1:0] a_in_eff;

    // Effective A as seen on the ports.
    always_comb begin
        a_in_eff = a_word;
        if (ratio_sel) a_in_eff[A_W-1] = 1'b0;
    end

    // Track the current cycle and remember the words taken at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            len_q   <= '0;
            modn_q  <= '0;
            exp_len <= '0;
            exp_a   <= '0;
            exp_ok  <= 1'b0;
        end else if (div_pulse) begin
            armed   <= 1'b1;
            len_q   <= '0;
            modn_q  <= '0;
            exp_len <= (m_word == '0) ? (M_W+1)'(1) : (M_W+1)'(m_word);
            exp_a   <= (M_W+1)'(a_in_eff);
            exp_ok  <= (m_word != '0) && (M_W'(a_in_eff) <= m_word);
        end else begin
            len_q   <= len_q + (M_W+1)'(1);
            modn_q  <= modn_q + (M_W+1)'(mod_ctl);
        end
    end

    // R4 / R5 / R8: the cycle length matches the M taken at its start.
    assert_cycle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && div_pulse) |-> (len_q + (M_W+1)'(1) == exp_len));

    // R3: the number of high-ratio pulses equals the A taken at the start.
    assert_swallow_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && div_pulse && exp_ok) |-> (modn_q + (M_W+1)'(mod_ctl) == exp_a));

    // R3: once low inside a cycle, mod_ctl stays low until the boundary.
    assert_mod_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_ctl && !div_pulse) |=> !mod_ctl);

    // R2: the ratio select follows the input taken at the boundary.
    assert_ratio_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> (psc_div8 == $past(ratio_sel)));

    // R2 / R5: the ratio select holds inside a cycle.
    assert_ratio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |=> $stable(psc_div8));

    // R7: the status holds inside a cycle.
    assert_invalid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |=> $stable(cfg_invalid));

    // R3: a new cycle opens with mod_ctl high exactly when A is non-zero.
    assert_mod_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> (mod_ctl == ($past(a_in_eff) != '0)));
endmodule

bind dm_swallow_div dm_swallow_div_chk #(.M_W(M_W), .A_W(A_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ratio_sel   (ratio_sel),
    .m_word      (m_word),
    .a_word      (a_word),
    .mod_ctl     (mod_ctl),
    .div_pulse   (div_pulse),
    .psc_div8    (psc_div8),
    .cfg_invalid (cfg_invalid)
);

// File: tb/dm_swallow_div_tb.sv
`timescale 1ns/1ps
// Directed bench. It models the prescaler by counting N or N+1 input
// cycles per prescaler pulse, according to mod_ctl.
module dm_swallow_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ratio_sel = 1'b0;
    logic [14:0] m_word = 15'd10;
    logic [3:0]  a_word = 4'd3;
    logic        mod_ctl;
    logic        div_pulse;
    logic        psc_div8;
    logic        cfg_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dm_swallow_div u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel   (ratio_sel),
        .m_word      (m_word),
        .a_word      (a_word),
        .mod_ctl     (mod_ctl),
        .div_pulse   (div_pulse),
        .psc_div8    (psc_div8),
        .cfg_invalid (cfg_invalid)
    );

    // Compare one value and count the result.
    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait until the last pulse of a cycle has been seen.
    task automatic sync_pulse();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (div_pulse) return;
        end
    endtask

    // Measure one full cycle, counting input cycles for low ratio n.
    task automatic measure(input int n, output longint tot, output int nmod,
                           output int nclk, output bit contig, output bit inv);
        bit seen_low;
        tot = 0; nmod = 0; nclk = 0; contig = 1'b1; seen_low = 1'b0; inv = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (i == 0) inv = cfg_invalid;
            nclk++;
            tot += mod_ctl ? n + 1 : n;
            if (mod_ctl) begin
                nmod++;
                if (seen_low) contig = 1'b0;
            end else begin
                seen_low = 1'b1;
            end
            if (div_pulse) return;
        end
    endtask

    // Apply one setting and check ratio, count, length and status.
    task automatic t_ratio(input string tag, input int m, input int a, input bit sel,
                           input longint exp_tot, input int exp_mod, input int exp_clk,
                           input bit exp_inv);
        longint tot; int nmod; int nclk; bit contig; bit inv;
        m_word = 15'(m); a_word = 4'(a); ratio_sel = sel;
        sync_pulse();
        measure(sel ? 8 : 16, tot, nmod, nclk, contig, inv);
        chk({tag, " ratio"}, tot, exp_tot);
        chk({tag, " R3 high-ratio count"}, nmod, exp_mod);
        chk({tag, " R3 high first"}, contig, 1);
        chk({tag, " R4 cycle length"}, nclk, exp_clk);
        chk({tag, " R7 status"}, inv, exp_inv);
        chk({tag, " R2 ratio select"}, psc_div8, sel);
    endtask

    // R10: the state held in reset and the first cycle after it.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 mod_ctl in reset", mod_ctl, 1);
        chk("R10 div_pulse in reset", div_pulse, 0);
        chk("R10 cfg_invalid in reset", cfg_invalid, 0);
        chk("R10 psc_div8 in reset", psc_div8, 0);
        rst_n = 1'b1;
    endtask

    // R5: a word change partway through a cycle waits for the boundary.
    task automatic t_reload();
        longint tot; int nmod; int nclk; bit contig; bit inv; bit sel_at_end;
        m_word = 15'd20; a_word = 4'd5; ratio_sel = 1'b0;
        sync_pulse();
        tot = 0; nmod = 0; nclk = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            nclk++;
            tot += mod_ctl ? 17 : 16;
            nmod += int'(mod_ctl);
            if (nclk == 4) begin
                m_word = 15'd9; a_word = 4'd2; ratio_sel = 1'b1;
            end
            if (div_pulse) begin
                sel_at_end = psc_div8;
                break;
            end
        end
        chk("R5 old cycle ratio", tot, 325);
        chk("R5 old cycle length", nclk, 20);
        chk("R5 old cycle high count", nmod, 5);
        chk("R5 ratio select held", sel_at_end, 0);
        measure(8, tot, nmod, nclk, contig, inv);
        chk("R5 new cycle ratio", tot, 74);
        chk("R5 new cycle length", nclk, 9);
        chk("R2 new select taken", psc_div8, 1);
    endtask

    // Run every scenario in order and print the summary.
    initial begin
        t_reset();
        t_ratio("R1 M10 A3",     10,  3, 1'b0, 163, 3, 10, 1'b0);
        t_ratio("R1 R7 A=M",      4,  4, 1'b0,  68, 4,  4, 1'b0);
        t_ratio("R9 M15 A0",     15,  0, 1'b0, 240, 0, 15, 1'b0);
        t_ratio("R9 M15 A15",    15, 15, 1'b0, 255, 15, 15, 1'b0);
        t_ratio("R9 M16 A0",     16,  0, 1'b0, 256, 0, 16, 1'b0);
        t_ratio("R2 R9 M7 A0",    7,  0, 1'b1,  56, 0,  7, 1'b0);
        t_ratio("R2 R9 M7 A7",    7,  7, 1'b1,  63, 7,  7, 1'b0);
        t_ratio("R2 M8 A0",       8,  0, 1'b1,  64, 0,  8, 1'b0);
        t_ratio("R6 top bit",     5, 10, 1'b1,  42, 2,  5, 1'b1);
        t_ratio("R8 M0",          0,  0, 1'b0,  16, 0,  1, 1'b1);
        t_reload();
        t_ratio("R11 max", 32767, 15, 1'b0, 524287, 15, 32767, 1'b0);
        // R7: A above M raises the status; only the flag is checked here.
        begin
            longint tot; int nmod; int nclk; bit contig; bit inv;
            m_word = 15'd2; a_word = 4'd5; ratio_sel = 1'b0;
            sync_pulse();
            measure(16, tot, nmod, nclk, contig, inv);
            chk("R7 A above M", inv, 1);
            chk("R7 A above M length", nclk, 2);
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule